// File: doc/BRIEF.md
# Global control and status register block

This block holds one 16-bit global control word on a simple synchronous register bus. It also holds a set of latched status flags and their interrupt mask. The control word drives several side effects. Two soft reset outputs hold the data path, or the whole block, in its default state. A one-cycle error-insert pulse is taken from one of two sources: a software bit or an external pin. The performance-monitor mode and trigger fields are passed to a neighbouring block.

Status flags latch on the rising edge of their raw event inputs. One control bit picks how software clears them: by a write-one-to-clear access, or by reading them. When any unmasked flag is set, the interrupt output is pulled low. When no flag is active, the output is either released (high impedance) or driven high, as a control bit selects. The output pin is given as an enable and data pair.

The register map is: address 0 holds the control word, address 1 the latched status, and address 2 the interrupt mask. Read data is registered and is valid on the cycle after the read strobe is sampled. A write takes effect on the clock edge that samples it.

Top module: `glb_ctl_regs`

## Requirements
- R1: After `rst_n` is released, the control word reads 0x0002, `dp_rst` is 1, `all_rst` is 0, and the status and mask registers read 0.
- R2: `dp_rst` is high whenever control bit 1 or bit 0 is set. With only bit 1 set, `all_rst` stays low. Clearing bit 1 with bit 0 clear releases `dp_rst`.
- R3: While control bit 0 is set, `all_rst` and `dp_rst` are high and the status and mask registers read 0. The other control bits are held at their defaults, so the control word reads 0x0003. Writes to the mask are ignored. Writing bit 0 low leaves the control word at 0x0002.
- R4: With bit 6 at 0, a write that takes bit 7 from 0 to 1 gives exactly one `err_pulse`, high for one cycle, in the cycle after the write edge. Writing bit 7 again while it is already 1 gives no pulse.
- R5: With bit 6 at 1, a rise of bit 7 gives no `err_pulse`.
- R6: With bit 6 at 1, each rising edge of `ext_err_in` gives exactly one one-cycle `err_pulse`. The pulse starts two clock edges after the input is sampled high. With bit 6 at 0, the input is ignored.
- R7: A status flag sets when its `stat_evt` bit rises. The flag stays set after the event drops, until it is cleared.
- R8: With bit 2 at 0, a write to address 1 clears exactly those flags whose written data bit is 1.
- R9: With bit 2 at 1, the flags returned by a read of address 1 clear on the following cycle, and writes to address 1 do not clear any flag. When a flag's event rises in the same cycle as its clear, the flag stays set.
- R10: When any flag is set with its mask bit at 1, `irq_oe` is 1 and `irq_out` is 0. Otherwise, `irq_oe` equals control bit 14 and `irq_out` is 1.
- R11: `pm_mode` follows control bits 5:4 and `pm_update` follows control bit 3.
- R12: Control bits 15 and 13:8 always read 0. Only bits 14 and 7:0 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low general reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| stat_evt | input | NSTAT | Raw status events |
| ext_err_in | input | 1 | External error-insert request (asynchronous) |
| dp_rst | output | 1 | Data path soft reset |
| all_rst | output | 1 | Full soft reset |
| err_pulse | output | 1 | One-cycle error-insert request |
| pm_mode | output | 2 | Performance-monitor update mode |
| pm_update | output | 1 | Performance-monitor update trigger |
| irq_oe | output | 1 | Interrupt pin drive enable |
| irq_out | output | 1 | Interrupt pin drive value |

## Verification
The hardest case to reach is a flag whose event rises in the same clock cycle as its read-clear. That clear happens one cycle after the registered read, so the stimulus raises the event on the very negative edge at which the read task returns. A second read must then still find the flag set. The full-reset hold is also hard to reach. The bench writes bit 0 together with other bits, then reads the control word back while the hold is active to see that only bits 0 and 1 remain.

// File: rtl/glb_ctl_regs.sv
module glb_ctl_regs #(
  parameter int ADDR_W = 2,
  parameter int NSTAT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [NSTAT-1:0]  stat_evt,
  input  logic              ext_err_in,
  output logic              dp_rst,
  output logic              all_rst,
  output logic              err_pulse,
  output logic [1:0]        pm_mode,
  output logic              pm_update,
  output logic              irq_oe,
  output logic              irq_out
);
  localparam logic [15:0] CTRL_DEF  = 16'h0002;
  localparam logic [15:0] CTRL_KEEP = 16'h40FF;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2);

  logic [15:0]      ctrl;
  logic [NSTAT-1:0] stat, mask, evt_prev, rd_snap, clr, rise;
  logic             rd_pend, man_prev;
  logic [2:0]       ext_sync;

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_stat = bus_we && bus_addr == A_STAT;
  wire wr_mask = bus_we && bus_addr == A_MASK;
  wire rd_clr_mode = ctrl[2];
  wire ext_rise = ext_sync[1] & ~ext_sync[2];
  wire man_rise = ctrl[7] & ~man_prev;
  wire irq_act = |(stat & mask);

  assign all_rst   = ctrl[0];
  assign dp_rst    = ctrl[0] | ctrl[1];
  assign pm_mode   = ctrl[5:4];
  assign pm_update = ctrl[3];
  assign err_pulse = ctrl[6] ? ext_rise : man_rise;
  assign irq_oe    = irq_act | ctrl[14];
  assign irq_out   = ~irq_act;
  assign rise      = stat_evt & ~evt_prev;

  always_comb begin
    clr = '0;
    if (rd_clr_mode) begin
      if (rd_pend) clr = rd_snap;
    end else if (wr_stat) begin
      clr = bus_wdata[NSTAT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_DEF;
    end else if (all_rst) begin
      ctrl <= CTRL_DEF;
      ctrl[0] <= wr_ctrl ? bus_wdata[0] : 1'b1;
    end else if (wr_ctrl) begin
      ctrl <= bus_wdata & CTRL_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '0;
      mask    <= '0;
      rd_pend <= 1'b0;
      rd_snap <= '0;
    end else if (all_rst) begin
      stat    <= '0;
      mask    <= '0;
      rd_pend <= 1'b0;
      rd_snap <= '0;
    end else begin
      stat    <= (stat & ~clr) | rise;
      if (wr_mask) mask <= bus_wdata[NSTAT-1:0];
      rd_pend <= bus_re && bus_addr == A_STAT && rd_clr_mode;
      rd_snap <= stat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev <= '0;
      ext_sync <= '0;
      man_prev <= 1'b0;
    end else begin
      evt_prev <= stat_evt;
      ext_sync <= {ext_sync[1:0], ext_err_in};
      man_prev <= ctrl[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl;
        A_STAT:  bus_rdata <= 16'(stat);
        A_MASK:  bus_rdata <= 16'(mask);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

module glb_ctl_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int NSTAT  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       ctrl,
  input logic [NSTAT-1:0]  stat,
  input logic              rd_pend,
  input logic              dp_rst,
  input logic              all_rst,
  input logic              err_pulse
);
  assert_full_holds_dp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    all_rst |-> dp_rst);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  assert_manual_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !ctrl[6]) |-> $past(bus_we && bus_addr == ADDR_W'(0) && bus_wdata[7]));

  assert_flag_clear_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat) & ~stat)) |->
      ($past(bus_we && bus_addr == ADDR_W'(1)) || $past(rd_pend) || $past(all_rst)));
endmodule

bind glb_ctl_regs glb_ctl_regs_chk #(.ADDR_W(ADDR_W), .NSTAT(NSTAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .ctrl(ctrl), .stat(stat), .rd_pend(rd_pend),
  .dp_rst(dp_rst), .all_rst(all_rst), .err_pulse(err_pulse)
);

// File: tb/test_glb_ctl_regs.sv
module test_glb_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'hFFFE, 16'h40FE},
    {16'h0032, 16'h0032},
    {16'h4004, 16'h4004},
    {16'h0008, 16'h0008},
    {16'hBF02, 16'h0002},
    {16'h0000, 16'h0000}
  };

  logic clk = 0, rst_n = 0, bus_we = 0, bus_re = 0, ext_err_in = 0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [7:0] stat_evt = '0;
  logic dp_rst, all_rst, err_pulse, pm_update, irq_oe, irq_out;
  logic [1:0] pm_mode;
  int checks = 0, failures = 0, pcnt = 0, c0;
  logic [15:0] r;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (err_pulse) pcnt++;

  glb_ctl_regs i_glb_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_evt(stat_evt),
    .ext_err_in(ext_err_in), .dp_rst(dp_rst), .all_rst(all_rst), .err_pulse(err_pulse),
    .pm_mode(pm_mode), .pm_update(pm_update), .irq_oe(irq_oe), .irq_out(irq_out));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic evt(logic [7:0] v);
    @(negedge clk); stat_evt = v;
    @(negedge clk); stat_evt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dp_rst", dp_rst, 1);
    chk("R1 all_rst", all_rst, 0);
    chk("R2 all_rst low with dp", all_rst, 0);
    rd(0, r); chk("R1 ctrl", r, 16'h0002);
    rd(1, r); chk("R1 stat", r, 0);
    rd(2, r); chk("R1 mask", r, 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(0, VEC[i][31:16]);
      rd(0, r);
      chk("R12 ctrl readback", r, VEC[i][15:0]);
      chk("R11 pm_mode", 16'(pm_mode), 16'(VEC[i][5:4]));
      chk("R11 pm_update", 16'(pm_update), 16'(VEC[i][3]));
    end
    chk("R2 dp released", dp_rst, 0);

    c0 = pcnt;
    wr(0, 16'h0080);
    chk("R4 pulse after write", err_pulse, 1);
    @(negedge clk); chk("R4 pulse one cycle", err_pulse, 0);
    wr(0, 16'h0080);
    repeat (3) @(negedge clk);
    chk("R4 single pulse count", 16'(pcnt - c0), 1);
    wr(0, 16'h0040);
    c0 = pcnt;
    wr(0, 16'h00C0);
    repeat (3) @(negedge clk);
    chk("R5 manual ignored", 16'(pcnt - c0), 0);

    wr(0, 16'h0040);
    c0 = pcnt;
    @(negedge clk); ext_err_in = 1;
    @(negedge clk); chk("R6 no pulse yet", err_pulse, 0);
    @(negedge clk); chk("R6 pulse", err_pulse, 1);
    @(negedge clk); chk("R6 pulse end", err_pulse, 0);
    repeat (3) @(negedge clk); ext_err_in = 0;
    repeat (4) @(negedge clk); ext_err_in = 1;
    repeat (5) @(negedge clk); ext_err_in = 0;
    repeat (4) @(negedge clk);
    chk("R6 two edges two pulses", 16'(pcnt - c0), 2);
    wr(0, 16'h0000);
    c0 = pcnt;
    @(negedge clk); ext_err_in = 1;
    repeat (5) @(negedge clk); ext_err_in = 0;
    repeat (4) @(negedge clk);
    chk("R6 ext ignored when manual", 16'(pcnt - c0), 0);

    evt(8'h05);
    repeat (2) @(negedge clk);
    rd(1, r); chk("R7 latched", r, 16'h0005);
    wr(1, 16'h0004);
    rd(1, r); chk("R8 w1c partial", r, 16'h0001);
    wr(1, 16'h0001);
    rd(1, r); chk("R8 w1c all", r, 16'h0000);

    wr(2, 16'h0002);
    evt(8'h02);
    chk("R10 irq_oe active", irq_oe, 1);
    chk("R10 irq_out low", irq_out, 0);
    wr(1, 16'h0002);
    chk("R10 idle released", irq_oe, 0);
    wr(0, 16'h4000);
    chk("R10 idle driven oe", irq_oe, 1);
    chk("R10 idle driven high", irq_out, 1);
    evt(8'h01);
    chk("R10 masked flag no irq", irq_out, 1);
    wr(1, 16'h0001);

    wr(0, 16'h0004);
    evt(8'h01);
    wr(1, 16'h00FF);
    rd(1, r); chk("R9 write no clear", r, 16'h0001);
    rd(1, r); chk("R9 read cleared", r, 16'h0000);
    evt(8'h01);
    rd(1, r); chk("R9 read value", r, 16'h0001);
    stat_evt = 8'h01;
    @(negedge clk); stat_evt = 8'h00;
    rd(1, r); chk("R9 set wins over clear", r, 16'h0001);
    rd(1, r); chk("R9 cleared after", r, 16'h0000);

    wr(0, 16'h0000);
    wr(2, 16'h0003);
    evt(8'h02);
    wr(0, 16'h40F1);
    @(negedge clk);
    chk("R3 all_rst", all_rst, 1);
    chk("R3 dp_rst", dp_rst, 1);
    rd(0, r); chk("R3 ctrl held", r, 16'h0003);
    wr(2, 16'h00FF);
    rd(2, r); chk("R3 mask cleared", r, 16'h0000);
    rd(1, r); chk("R3 stat cleared", r, 16'h0000);
    chk("R3 irq idle", irq_oe, 0);
    wr(0, 16'h0000);
    chk("R3 all_rst released", all_rst, 0);
    rd(0, r); chk("R3 ctrl defaults", r, 16'h0002);
    chk("R3 dp still held", dp_rst, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule